// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small accumulator-based processor. It takes the accumulator value and a second operand and applies the operation selected by a 4-bit code. It returns the 8-bit result at once, without waiting for a clock edge. It also returns a write strobe for the accumulator and the flag byte the operation would produce. That flag byte is held in a register inside the block. The register supplies the carry-in for the carry-dependent operations and is visible on its own output.

The surrounding datapath presents the operands and the code, and raises `op_en` to commit the operation. On the next rising clock edge the flag register takes the new value. The datapath uses `acc_we` to decide whether `result` goes back into the accumulator. Operations that change no flag leave the register untouched, and so do flag bits that an operation does not affect.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 complement, 9 increment, 10 decrement, 11 rotate left circular, 12 rotate right circular, 13 rotate left through carry, 14 rotate right through carry, 15 pass (result equals the accumulator). `acc_we` is high when `op_en` is high and the code is neither 7 nor 15.
- R2: Flag byte layout: bit 7 sign, bit 6 zero, bit 4 auxiliary carry, bit 2 parity, bit 0 carry. Bits 5, 3 and 1 always read 0, on both `flags` and `flag_next`.
- R3: For codes 0 to 7, 9 and 10, the sign flag is bit 7 of the computed value. The zero flag is 1 when that value is 0x00. The parity flag is 1 when the value has an even number of ones. For compare, the computed value is the difference.
- R4: Add and add-with-carry form A + B (+ carry flag for code 1). The carry flag is the carry out of bit 7. The auxiliary carry is the carry out of bit 3.
- R5: Subtract and subtract-with-borrow form A - B (- carry flag for code 3) as A + ~B + cin, with cin = 1 for code 2 and cin = NOT carry flag for code 3. The carry flag is the inverse of the carry out of bit 7, which marks a borrow. The auxiliary carry is the carry out of bit 3 of that same addition.
- R6: AND, OR and XOR clear both the carry flag and the auxiliary carry flag.
- R7: Compare sets all five flags exactly as subtract (code 2) would, but `acc_we` stays low.
- R8: Complement outputs ~A and leaves every flag unchanged.
- R9: Increment gives A+1, with the auxiliary carry set when A[3:0] = 0xF. Decrement gives A-1, with the auxiliary carry set when A[3:0] is not 0. Both leave the carry flag unchanged.
- R10: Rotate-left-circular copies bit 7 into bit 0 and into carry. Rotate-right-circular copies bit 0 into bit 7 and into carry.
- R11: Rotate-left-through-carry shifts bit 7 into carry and the old carry into bit 0. Rotate-right-through-carry shifts bit 0 into carry and the old carry into bit 7. All four rotates leave sign, zero, auxiliary carry and parity unchanged.
- R12: Reset clears the flag register. The register loads `flag_next` only on a rising edge with `op_en` high. Code 15 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_en | input | 1 | Commit the current operation |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand A |
| opnd | input | 8 | Second operand B |
| result | output | 8 | Combinational result |
| acc_we | output | 1 | Accumulator write strobe |
| flag_next | output | 8 | Flag byte the current operation would produce |
| flags | output | 8 | Registered flag byte |

## Verification
The hardest cases to reach are the ones where the outcome depends on the carry left behind by an earlier operation. These are add with carry, subtract with borrow and the rotates through carry. The bench reaches them by first running an operation whose carry it knows: an add that overflows, a subtract that borrows, or a logic operation that clears carry. It then issues the carry-dependent code and checks both the value shifted or added in and the flags that must not move. It also checks that the flags hold across a cycle with `op_en` low.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_en,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] result,
  output logic         acc_we,
  output logic [7:0]   flag_next,
  output logic [7:0]   flags
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
                         OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_CMP = 4'd7,
                         OP_CPL = 4'd8, OP_INC = 4'd9, OP_DEC = 4'd10, OP_RLC = 4'd11,
                         OP_RRC = 4'd12, OP_RAL = 4'd13, OP_RAR = 4'd14, OP_PAS = 4'd15;
  localparam int H = W / 2;

  logic         cy_q;
  logic [W-1:0] b_eff, val;
  logic         cin, c_out, h_out;
  logic [W:0]   sum;
  logic [H:0]   hsum;
  logic         s_n, z_n, ac_n, p_n, c_n;

  assign cy_q = flags[0];

  always_comb begin
    b_eff = opnd;
    cin   = 1'b0;
    case (op)
      OP_ADC:         cin = cy_q;
      OP_SUB, OP_CMP: begin b_eff = ~opnd; cin = 1'b1; end
      OP_SBB:         begin b_eff = ~opnd; cin = ~cy_q; end
      OP_INC:         begin b_eff = '0; cin = 1'b1; end
      OP_DEC:         b_eff = '1;
      default: ;
    endcase
  end

  assign sum   = {1'b0, acc_in} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign hsum  = {1'b0, acc_in[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin};
  assign c_out = sum[W];
  assign h_out = hsum[H];

  always_comb begin
    val = sum[W-1:0];
    case (op)
      OP_AND: val = acc_in & opnd;
      OP_OR:  val = acc_in | opnd;
      OP_XOR: val = acc_in ^ opnd;
      default: ;
    endcase
  end

  always_comb begin
    result = val;
    case (op)
      OP_CMP, OP_PAS: result = acc_in;
      OP_CPL: result = ~acc_in;
      OP_RLC: result = {acc_in[W-2:0], acc_in[W-1]};
      OP_RRC: result = {acc_in[0], acc_in[W-1:1]};
      OP_RAL: result = {acc_in[W-2:0], cy_q};
      OP_RAR: result = {cy_q, acc_in[W-1:1]};
      default: ;
    endcase
  end

  always_comb begin
    s_n  = flags[7];
    z_n  = flags[6];
    ac_n = flags[4];
    p_n  = flags[2];
    c_n  = cy_q;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP, OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        s_n = val[W-1];
        z_n = (val == '0);
        p_n = ~^val;
        ac_n = h_out;
        case (op)
          OP_ADD, OP_ADC:         c_n = c_out;
          OP_SUB, OP_SBB, OP_CMP: c_n = ~c_out;
          OP_AND, OP_OR, OP_XOR:  begin c_n = 1'b0; ac_n = 1'b0; end
          default: ;
        endcase
      end
      OP_RLC, OP_RAL: c_n = acc_in[W-1];
      OP_RRC, OP_RAR: c_n = acc_in[0];
      default: ;
    endcase
  end

  assign flag_next = {s_n, z_n, 1'b0, ac_n, 1'b0, p_n, 1'b0, c_n};
  assign acc_we    = op_en && (op != OP_CMP) && (op != OP_PAS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     flags <= '0;
    else if (op_en) flags <= flag_next;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_en,
  input logic [3:0] op,
  input logic [7:0] acc_in,
  input logic [7:0] result,
  input logic       acc_we,
  input logic [7:0] flag_next,
  input logic [7:0] flags
);
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[5] | flags[3] | flags[1] | flag_next[5] | flag_next[3] | flag_next[1]) == 1'b0);

  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7) |-> !acc_we);

  a_r7_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7) |-> (result == acc_in));

  a_r9_incdec_carry_held: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op == 4'd9 || op == 4'd10)) |=> (flags[0] == $past(flags[0])));

  a_r11_rot_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op >= 4'd11 && op <= 4'd14) |=> ((flags & 8'hD4) == $past(flags & 8'hD4)));

  a_r3_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op <= 4'd2 || op == 4'd4 || op == 4'd5 || op == 4'd6 || op == 4'd9 || op == 4'd10))
      |=> (flags[2] == ~^$past(result)));

  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(flags));

  a_r8_cpl_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd8 || op == 4'd15) |-> (flag_next == flags));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .acc_in(acc_in),
  .result(result), .acc_we(acc_we), .flag_next(flag_next), .flags(flags)
);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       op_en = 0;
  logic [3:0] op = 4'd15;
  logic [7:0] acc_in = 0, opnd = 0;
  logic [7:0] result, flag_next, flags;
  logic       acc_we;
  int total = 0, bad = 0;
  logic [7:0] mfl = 0;

  always #2.5 clk = ~clk;

  alu8_flags uut (.clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .acc_in(acc_in),
    .opnd(opnd), .result(result), .acc_we(acc_we), .flag_next(flag_next), .flags(flags));

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [7:0] r, input logic ac, input logic c);
    return {r[7], r == 8'h00, 1'b0, ac, 1'b0, ~^r, 1'b0, c};
  endfunction

  // reference model from the requirements: returns {we, result, flags}
  function automatic logic [16:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    logic [8:0] s; logic [4:0] h; logic [7:0] r; logic [7:0] nf; logic we; logic ci;
    we = 1; nf = f; r = a;
    case (o)
      4'd0, 4'd1: begin ci = (o == 4'd1) ? f[0] : 1'b0;
        s = a + b + ci; h = a[3:0] + b[3:0] + ci; r = s[7:0]; nf = mk(r, h[4], s[8]); end
      4'd2, 4'd3, 4'd7: begin ci = (o == 4'd3) ? ~f[0] : 1'b1;
        s = a + {1'b0, ~b} + ci; h = a[3:0] + {1'b0, ~b[3:0]} + ci;
        nf = mk(s[7:0], h[4], ~s[8]);
        if (o == 4'd7) we = 0; else r = s[7:0]; end
      4'd4: begin r = a & b; nf = mk(r, 0, 0); end
      4'd5: begin r = a | b; nf = mk(r, 0, 0); end
      4'd6: begin r = a ^ b; nf = mk(r, 0, 0); end
      4'd8: r = ~a;
      4'd9: begin r = a + 1; nf = mk(r, a[3:0] == 4'hF, f[0]); end
      4'd10: begin r = a - 1; nf = mk(r, a[3:0] != 4'h0, f[0]); end
      4'd11: begin r = {a[6:0], a[7]}; nf[0] = a[7]; end
      4'd12: begin r = {a[0], a[7:1]}; nf[0] = a[0]; end
      4'd13: begin r = {a[6:0], f[0]}; nf[0] = a[7]; end
      4'd14: begin r = {f[0], a[7:1]}; nf[0] = a[0]; end
      default: we = 0;
    endcase
    return {we, r, nf};
  endfunction

  task automatic run(input string tag, input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
    logic [16:0] m;
    @(negedge clk);
    op = o; acc_in = a; opnd = b; op_en = 1;
    m = model(o, a, b, mfl);
    #1;
    chk({tag, " result"}, result, m[15:8]);
    chk({tag, " acc_we"}, {7'b0, acc_we}, {7'b0, m[16]});
    chk({tag, " flag_next"}, flag_next, m[7:0]);
    @(posedge clk); #1;
    mfl = m[7:0];
    op_en = 0;
    chk({tag, " flags"}, flags, mfl);
  endtask

  task automatic t_reset;
    chk("R12 reset flags", flags, 8'h00);
  endtask

  task automatic t_add;
    run("R4 add ovf", 4'd0, 8'hB5, 8'h6C);
    run("R4 add zero", 4'd0, 8'hB3, 8'h4D);
    run("R4 adc cin1", 4'd1, 8'h0F, 8'h00);
    run("R4 adc cin0", 4'd1, 8'h7F, 8'h01);
  endtask

  task automatic t_sub;
    run("R5 sub borrow", 4'd2, 8'hB5, 8'hCC);
    run("R5 sbb bin1", 4'd3, 8'h10, 8'h01);
    run("R5 sub eq", 4'd2, 8'h42, 8'h42);
    run("R5 sbb bin0", 4'd3, 8'h80, 8'h7F);
  endtask

  task automatic t_logic;
    run("R6 set carry", 4'd0, 8'hFF, 8'hFF);
    run("R6 and", 4'd4, 8'hF0, 8'h3C);
    run("R6 set carry2", 4'd0, 8'h88, 8'h88);
    run("R6 or", 4'd5, 8'h00, 8'h00);
    run("R6 xor", 4'd6, 8'hA5, 8'h5A);
  endtask

  task automatic t_cmp;
    run("R7 cmp lt", 4'd7, 8'h10, 8'h20);
    run("R7 cmp eq", 4'd7, 8'h55, 8'h55);
  endtask

  task automatic t_cpl;
    run("R3 prep", 4'd0, 8'hF8, 8'h08);
    run("R8 cpl", 4'd8, 8'h3C, 8'h00);
  endtask

  task automatic t_incdec;
    run("R9 prep carry", 4'd0, 8'hF0, 8'h20);
    run("R9 inc nib", 4'd9, 8'h0F, 8'h00);
    run("R9 inc wrap", 4'd9, 8'hFF, 8'h00);
    run("R9 dec to zero", 4'd10, 8'h01, 8'h00);
    run("R9 dec wrap", 4'd10, 8'h00, 8'h00);
  endtask

  task automatic t_rot;
    run("R10 rlc", 4'd11, 8'h81, 8'h00);
    run("R10 rrc", 4'd12, 8'h02, 8'h00);
    run("R11 prep c1", 4'd0, 8'hFF, 8'h02);
    run("R11 ral", 4'd13, 8'h40, 8'h00);
    run("R11 rar", 4'd14, 8'h01, 8'h00);
    run("R11 rar c1", 4'd14, 8'h10, 8'h00);
  endtask

  task automatic t_hold;
    run("R12 prep", 4'd2, 8'h00, 8'h01);
    @(negedge clk);
    op = 4'd4; acc_in = 8'h00; opnd = 8'h00; op_en = 0;
    @(posedge clk); #1;
    chk("R12 idle hold", flags, mfl);
    chk("R1 idle no we", {7'b0, acc_we}, 8'h00);
    run("R12 pass", 4'd15, 8'h77, 8'h00);
    run("R1 pass2", 4'd15, 8'h00, 8'hFF);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 64; i++)
      run("R1 sweep", i[3:0], 8'(i * 37 + 5), 8'(i * 91 + 13));
  endtask

  initial begin
    #1;
    t_reset;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    t_add; t_sub; t_logic; t_cmp; t_cpl; t_incdec; t_rot; t_hold; t_sweep;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule